// File: doc/BRIEF.md
# Multi-Hit Interval Time Digitizer Channel

This block is one stand-alone channel of a time digitizer. It measures the time between successive events on a hit line by counting enabled clock ticks. A start pulse arms the channel and zeroes the counter. From then on, every accepted hit does three things: it takes the running tick count, puts that value into a fixed-depth result buffer and restarts the count at zero. A burst of hits therefore gives a queue of consecutive intervals, not absolute time stamps. The first interval is measured from the start pulse.

A stop pulse closes the acquisition window. After that, the buffered words drain through a parallel-to-serial shifter, one bit per slow read strobe, with the oldest word first. Each word has a marker bit followed by the count. The channel has no cross-channel signals, so any number of copies can sit side by side with only the counting clock, start and stop in common.

Top module: `hit_interval_tdc`

## Requirements
- R1: After reset, `empty_o`=1, `overflow_o`=0, `armed_o`=0, `word_start_o`=0 and `ser_o`=0.
- R2: While armed, with `tick_en_i` high throughout, a hit that arrives N cycles after the start pulse or the previous accepted hit stores the value N. The first value is measured from the start pulse.
- R3: A hit that arrives while the buffer already holds DEPTH words is dropped. It sets `overflow_o`, which stays set until the next start. The words already stored are kept unchanged and in order.
- R4: The count saturates at all ones (255 for an 8-bit count) instead of wrapping. The saturated value is stored on the next hit.
- R5: A cycle in which `tick_en_i` is low, including the hit cycle itself, adds nothing to the interval. The stored value equals the number of enabled cycles in the interval.
- R6: `start_i` arms the channel and clears the count, the buffer, the shifter and `overflow_o`. A hit in the same cycle as a start is ignored.
- R7: `stop_i` disarms the channel. Hits while the channel is not armed are ignored. No word is shifted out while the channel is armed.
- R8: Each word is CNT_W+1 bits. The first bit out is a marker bit fixed at 1, followed by the count MSB first. Words come out oldest first. `word_start_o` pulses for one cycle when a word is loaded; at that point `ser_o` shows the marker. Each `rd_strobe_i` advances `ser_o` by one bit.
- R9: `empty_o` is 1 exactly when the buffer holds no word and the shifter holds no unfinished word.
- R10: Hits that arrive before the first start are ignored and leave `empty_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Common start pulse; arms the channel and clears all state |
| stop_i | input | 1 | Common stop pulse; closes the acquisition window |
| tick_en_i | input | 1 | Tick gate; the count holds while it is low |
| hit_i | input | 1 | Single-cycle hit event |
| rd_strobe_i | input | 1 | Slow read strobe; shifts one bit per pulse |
| ser_o | output | 1 | Serial data, current bit |
| word_start_o | output | 1 | One-cycle pulse when a new word is loaded into the shifter |
| empty_o | output | 1 | No stored or partly read word remains |
| overflow_o | output | 1 | Sticky flag; a hit was dropped because the buffer was full |
| armed_o | output | 1 | Acquisition window is open |

## Verification
The hardest state to reach is a full buffer with more hits still arriving. It takes a long, exactly timed train of hits inside one window, and the channel must then still drain every kept word unchanged. The stimulus sends eleven hits with growing spacing into a nine-word buffer, checks the sticky flag, and reads all nine words back in order. Saturation also needs an interval longer than the count range, and gated ticks need `tick_en_i` to fall in the middle of an interval, including on the hit cycle. Both are produced by rows of the interval table, which replays per-row spacing and gating within a single window.

// File: rtl/tdc_pkg.sv
// Shared definitions for the interval time digitizer channel.
// Assumes nothing beyond standard SystemVerilog.
package tdc_pkg;
    // Marker bit placed ahead of the count field in every stored word
    localparam logic WORD_MARK = 1'b1;

    // Parallel-to-serial shifter states
    typedef enum logic {
        SER_IDLE  = 1'b0,
        SER_SHIFT = 1'b1
    } ser_state_t;
endpackage

// File: rtl/tdc_interval_counter.sv
// Saturating interval counter. The sample output already includes
// the current cycle's tick, so a hit captures the full interval.
// Assumes the hit strobe is asserted only while the channel is running.
module tdc_interval_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic             tick_en_i,
    input  logic             hit_take_i,
    output logic [CNT_W-1:0] sample_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Next count value: one tick added when enabled, held at all ones
    always_comb begin
        if (tick_en_i && (cnt_q != CNT_MAX)) begin
            sample_o = cnt_q + CNT_ONE;
        end else begin
            sample_o = cnt_q;
        end
    end

    // Count register: cleared by start or by an accepted hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            if (hit_take_i) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= sample_o;
            end
        end
    end
endmodule

// File: rtl/tdc_hit_fifo.sv
// Fixed-depth first-in first-out buffer of captured words.
// A push while full is refused, so stored words are never overwritten.
// Depth may be any value of 1 or more.
module tdc_hit_fifo #(
    parameter int WORD_W = 17,
    parameter int DEPTH  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [WORD_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [WORD_W-1:0] pop_data_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] PTR_ONE  = {{(PTR_W-1){1'b0}}, 1'b1};
    localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
    localparam logic [OCC_W-1:0] OCC_ONE  = {{(OCC_W-1){1'b0}}, 1'b1};

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [OCC_W-1:0]  occ_q;
    logic              do_push, do_pop;

    // Status decode and effective push/pop
    always_comb begin
        empty_o    = (occ_q == '0);
        full_o     = (occ_q == OCC_FULL);
        do_push    = push_i && !full_o;
        do_pop     = pop_i && !empty_o;
        pop_data_o = mem_q[rd_ptr_q];
    end

    // Storage array: one write port per entry
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[gi] <= '0;
            end else if (do_push && !flush_i && (wr_ptr_q == PTR_W'(gi))) begin
                mem_q[gi] <= push_data_i;
            end
        end
    end

    // Pointers and occupancy, with wrap at a non power-of-two depth
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + PTR_ONE;
            end
            if (do_pop) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + PTR_ONE;
            end
            case ({do_push, do_pop})
                2'b10:   occ_q <= occ_q + OCC_ONE;
                2'b01:   occ_q <= occ_q - OCC_ONE;
                default: occ_q <= occ_q;
            endcase
        end
    end
endmodule

// File: rtl/tdc_serializer.sv
// Parallel-to-serial shifter. Loads one word whenever it is idle,
// enabled and a word is available, then shifts MSB first, one bit
// per read strobe. Assumes the word is stable while pop_o is high.
module tdc_serializer #(
    parameter int WORD_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              enable_i,
    input  logic              avail_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              strobe_i,
    output logic              pop_o,
    output logic              ser_o,
    output logic              word_start_o,
    output logic              busy_o
);
    import tdc_pkg::*;

    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] BIT_ONE  = {{(BIT_W-1){1'b0}}, 1'b1};

    ser_state_t        state_q;
    logic [WORD_W-1:0] shreg_q;
    logic [BIT_W-1:0]  left_q;

    // Load request and output taps
    always_comb begin
        pop_o  = (state_q == SER_IDLE) && enable_i && avail_i && !flush_i;
        ser_o  = shreg_q[WORD_W-1];
        busy_o = (state_q == SER_SHIFT);
    end

    // Shift engine: load, shift on strobe, return to idle after last bit
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            state_q      <= SER_IDLE;
            shreg_q      <= '0;
            left_q       <= '0;
            word_start_o <= 1'b0;
        end else begin
            word_start_o <= pop_o;
            if (pop_o) begin
                state_q <= SER_SHIFT;
                shreg_q <= word_i;
                left_q  <= BIT_LAST;
            end else if ((state_q == SER_SHIFT) && strobe_i) begin
                shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                if (left_q == '0) begin
                    state_q <= SER_IDLE;
                end else begin
                    left_q <= left_q - BIT_ONE;
                end
            end
        end
    end
endmodule

// File: rtl/hit_interval_tdc.sv
// One multi-hit interval digitizer channel. Start arms and clears,
// each accepted hit stores the interval since the previous event,
// stop closes the window, and stored words then drain serially.
// Assumes all control inputs are single-cycle synchronous pulses.
module hit_interval_tdc #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic tick_en_i,
    input  logic hit_i,
    input  logic rd_strobe_i,
    output logic ser_o,
    output logic word_start_o,
    output logic empty_o,
    output logic overflow_o,
    output logic armed_o
);
    import tdc_pkg::*;

    localparam int WORD_W = CNT_W + 1;

    logic              armed_q, overflow_q;
    logic              hit_take;
    logic [CNT_W-1:0]  sample;
    logic [WORD_W-1:0] head_word;
    logic              fifo_empty, fifo_full, pop, ser_busy;

    // A hit counts only inside the window and never alongside a start
    always_comb begin
        hit_take = hit_i && armed_q && !start_i;
    end

    // Window state: start wins over stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (start_i) begin
            armed_q <= 1'b1;
        end else if (stop_i) begin
            armed_q <= 1'b0;
        end
    end

    // Sticky record of hits refused by a full buffer
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            overflow_q <= 1'b0;
        end else if (hit_take && fifo_full) begin
            overflow_q <= 1'b1;
        end
    end

    tdc_interval_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .run_i      (armed_q),
        .tick_en_i  (tick_en_i),
        .hit_take_i (hit_take),
        .sample_o   (sample)
    );

    tdc_hit_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (start_i),
        .push_i      (hit_take),
        .push_data_i ({WORD_MARK, sample}),
        .pop_i       (pop),
        .pop_data_o  (head_word),
        .empty_o     (fifo_empty),
        .full_o      (fifo_full)
    );

    tdc_serializer #(.WORD_W(WORD_W)) u_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (start_i),
        .enable_i     (!armed_q),
        .avail_i      (!fifo_empty),
        .word_i       (head_word),
        .strobe_i     (rd_strobe_i),
        .pop_o        (pop),
        .ser_o        (ser_o),
        .word_start_o (word_start_o),
        .busy_o       (ser_busy)
    );

    // Port drive
    always_comb begin
        empty_o    = fifo_empty && !ser_busy;
        overflow_o = overflow_q;
        armed_o    = armed_q;
    end
endmodule

// File: rtl/tdc_checker.sv
// Temporal checks on the channel ports, bound to every instance.
module tdc_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic stop_i,
    input logic armed_o,
    input logic overflow_o,
    input logic empty_o,
    input logic word_start_o
);
    p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (armed_o && !overflow_o && empty_o));

    p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !start_i) |=> overflow_o);

    p_stop_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !armed_o);

    p_no_read_while_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |-> !word_start_o);

    p_word_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_start_o |=> !word_start_o);

    p_loaded_not_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_start_o |-> !empty_o);
endmodule

bind hit_interval_tdc tdc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .armed_o      (armed_o),
    .overflow_o   (overflow_o),
    .empty_o      (empty_o),
    .word_start_o (word_start_o)
);

// File: tb/sim_hit_interval_tdc.sv
`timescale 1ns/1ps
module sim_hit_interval_tdc;
    localparam int CNT_W = 8;
    localparam int DEPTH = 9;
    localparam int W     = CNT_W + 1;
    localparam int NVEC  = 6;
    // Each row: interval length, gated cycles at its start, expected value
    localparam int VEC [NVEC][3] = '{
        '{5,   0,  5},
        '{1,   0,  1},
        '{20,  5,  15},
        '{300, 0,  255},
        '{40,  40, 0},
        '{256, 0,  255}
    };

    logic clk = 1'b0;
    logic rst_n, start_i, stop_i, tick_en_i, hit_i, rd_strobe_i;
    logic ser_o, word_start_o, empty_o, overflow_o, armed_o;
    int   n_chk = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;

    hit_interval_tdc #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .tick_en_i(tick_en_i), .hit_i(hit_i), .rd_strobe_i(rd_strobe_i),
        .ser_o(ser_o), .word_start_o(word_start_o), .empty_o(empty_o),
        .overflow_o(overflow_o), .armed_o(armed_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        start_i = 1'b1; step(); start_i = 1'b0;
    endtask

    task automatic do_stop();
        stop_i = 1'b1; step(); stop_i = 1'b0;
    endtask

    // Interval of len cycles, tick gate low for the first off cycles
    task automatic interval(input int len, input int off);
        for (int c = 1; c <= len; c++) begin
            tick_en_i = (c <= off) ? 1'b0 : 1'b1;
            hit_i     = (c == len);
            step();
        end
        hit_i = 1'b0;
        tick_en_i = 1'b1;
    endtask

    // Wait for a word, then shift it out one strobe per bit
    task automatic read_word(input string req, input int exp_cnt);
        logic [W-1:0] v = '0;
        int found = 0;
        for (int t = 0; t < 40 && found == 0; t++) begin
            if (word_start_o) found = 1; else step();
        end
        check({req, " word_start seen"}, found, 1);
        for (int b = 0; b < W; b++) begin
            v = {v[W-2:0], ser_o};
            rd_strobe_i = 1'b1; step(); rd_strobe_i = 1'b0;
        end
        check({req, " R8 word"}, int'(v), int'({1'b1, 8'(exp_cnt)}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; tick_en_i = 1'b1;
        hit_i = 1'b0; rd_strobe_i = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        check("R1 empty", empty_o, 1);
        check("R1 overflow", overflow_o, 0);
        check("R1 armed", armed_o, 0);
        check("R1 word_start", word_start_o, 0);
        check("R1 ser", ser_o, 0);

        // R10: hits before any start are ignored
        hit_i = 1'b1; step(); hit_i = 1'b0; step();
        hit_i = 1'b1; step(); hit_i = 1'b0; step();
        check("R10 empty after early hits", empty_o, 1);

        // Table walk: R2, R4, R5 intervals in one window, R8 readout order
        do_start();
        check("R6 armed after start", armed_o, 1);
        for (int i = 0; i < NVEC; i++) begin
            interval(VEC[i][0], VEC[i][1]);
            if (i == 0) begin
                check("R7 no word_start while armed", word_start_o, 0);
                check("R9 not empty with stored word", empty_o, 0);
            end
        end
        repeat (3) step();
        check("R7 no word_start while armed", word_start_o, 0);
        do_stop();
        check("R7 disarmed after stop", armed_o, 0);
        for (int i = 0; i < NVEC; i++) begin
            read_word("R2 R4 R5 table", VEC[i][2]);
        end
        step();
        check("R9 empty after drain", empty_o, 1);

        // R3: eleven hits into a nine-word buffer
        do_start();
        for (int k = 2; k <= 12; k++) interval(k, 0);
        check("R3 overflow set", overflow_o, 1);
        do_stop();
        for (int k = 2; k <= 10; k++) read_word("R3 kept word", k);
        step();
        check("R9 empty after overflow drain", empty_o, 1);
        check("R3 overflow still sticky", overflow_o, 1);

        // R6: start clears overflow and buffer, start+hit ignores the hit
        do_start();
        check("R6 overflow cleared", overflow_o, 0);
        interval(4, 0);
        start_i = 1'b1; hit_i = 1'b1; step(); start_i = 1'b0; hit_i = 1'b0;
        check("R6 buffer cleared, coincident hit ignored", empty_o, 1);
        interval(7, 0);
        do_stop();
        // R7: a hit after stop is ignored
        hit_i = 1'b1; step(); hit_i = 1'b0;
        read_word("R6 measured from start", 7);
        repeat (3) step();
        check("R7 post-stop hit not stored", empty_o, 1);
        check("R7 no further word", word_start_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule